// File: doc/BRIEF.md
# Block-Write Configuration Target for a Clock Generator

This block is a two-wire serial-bus target that loads a bank of byte-wide configuration registers for a clock generator. A system clock samples SCL and SDA. The block looks for start and stop conditions, then compares the first byte of a transfer against a fixed 7-bit device address. Every transfer it accepts is a block write. After the address, the controller sends a command byte and then a length byte. The payload that follows is stored from register 0 upward.

The block acknowledges bytes by pulling SDA low through an open-drain enable. It never drives SCL, so it cannot stretch the clock. A power-down input freezes the block: while it is high, bus activity is ignored and the register contents stay as they are. The whole bank is available as one wide parallel output that feeds the clock generator's divider and enable logic.

Top module: `cfg_blkwr_slave`

## Requirements
- R1: SCL and SDA each pass through a two-flop synchronizer. On the synchronized samples, a falling SDA while SCL is high is a start condition, and a rising SDA while SCL is high is a stop condition.
- R2: The target acknowledges the first byte after a start only when its upper seven bits equal DEV_ADDR and bit 0 (the direction bit) is 0. Bits arrive MSB first. Read requests, the all-zero general-call address and other addresses get no acknowledge, and the target ignores the bus until the next start.
- R3: After a matching address, the target acknowledges every later byte of the transfer. sda_oe_o goes high after the SCL fall that ends the eighth bit, and goes low after the SCL fall that ends the ninth clock.
- R4: The byte after the address is the command, and it must equal CMD_CODE (0x00). The next byte is the payload length, which must be 1 to 32. If either byte is wrong, every payload byte is acknowledged but none is written.
- R5: Payload byte k, counting from 0, is written to register k. Register k is output on cfg_o[8k+7:8k]. Bytes at positions at or past the length byte, or at or past NREG, are acknowledged but not written.
- R6: A stop or a repeated start ends the transfer. Registers already written keep their new values. A repeated start begins a new address phase, and each new transfer needs its own command and length bytes and loads again from register 0.
- R7: While pdn_i is 1, bus activity has no effect: sda_oe_o stays 0 and every register keeps its value.
- R8: sda_oe_o is high only inside acknowledge clock periods. The target has no output on SCL.
- R9: After the synchronous reset rst, every register reads 0 and sda_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| pdn_i | input | 1 | Power-down: bus ignored, registers kept |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfg_o | output | NREG*8 | Register bank, register k on bits 8k+7:8k |

## Verification
A change on SCL reaches the byte-control logic two flops later, so the acknowledge enable rises on the third clock after the SCL fall that ends a byte. The register write comes one clock after that. The bench holds each SCL half period for 16 clocks and reads sda_oe_o halfway through the high phase of the ninth clock, long after that three-clock delay. It compares the register bank only after the stop condition, so every write has settled. A monitor marks the acknowledge windows with four clocks of slack after the ninth SCL fall, because the enable needs three clocks to drop. Any enable seen outside those windows is counted against R8.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_BITS,
    PH_ACK,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/cfgw_sampler.sv
module cfgw_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  // bit 1 = SCL, bit 0 = SDA; last entry is the history stage
  logic [1:0] pipe [SYNC_STAGES+1];
  logic [1:0] now_s, prev_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= SYNC_STAGES; i++) pipe[i] <= 2'b11;
    end else begin
      pipe[0] <= {scl_i, sda_i};
      for (int i = 1; i <= SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign now_s     = pipe[SYNC_STAGES-1];
  assign prev_s    = pipe[SYNC_STAGES];
  assign sda_lvl   = now_s[0];
  assign scl_rise  = now_s[1] && !prev_s[1];
  assign scl_fall  = !now_s[1] && prev_s[1];
  assign start_evt = now_s[1] && prev_s[1] && prev_s[0] && !now_s[0];
  assign stop_evt  = now_s[1] && prev_s[1] && !prev_s[0] && now_s[0];
endmodule

// File: rtl/cfgw_xfer.sv
module cfgw_xfer
  import cfgw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] CMD_CODE = 8'h00,
  parameter int NREG    = 32,
  parameter int MAX_CNT = 32,
  localparam int AW = $clog2(NREG),
  localparam int CW = $clog2(MAX_CNT + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pdn_i,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  output logic          sda_oe_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o
);
  phase_t        phase;
  logic [3:0]    bit_cnt;
  logic [1:0]    hdr_idx;   // 0 address, 1 command, 2 length, 3 payload
  logic [CW-1:0] data_idx;
  logic [7:0]    shreg;
  logic [7:0]    cnt_q;
  logic          cmd_ok;
  logic          store_ok;

  assign store_ok = cmd_ok && (cnt_q != 8'd0) && (int'(cnt_q) <= MAX_CNT)
                    && (int'(data_idx) < int'(cnt_q)) && (int'(data_idx) < NREG);

  always_ff @(posedge clk) begin
    if (rst || pdn_i) begin
      phase    <= PH_IDLE;
      sda_oe_o <= 1'b0;
      we_o     <= 1'b0;
      bit_cnt  <= 4'd0;
      hdr_idx  <= 2'd0;
      data_idx <= '0;
      shreg    <= 8'd0;
      cnt_q    <= 8'd0;
      cmd_ok   <= 1'b0;
      waddr_o  <= '0;
      wdata_o  <= 8'd0;
    end else begin
      we_o <= 1'b0;
      if (stop_evt) begin
        phase    <= PH_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_evt) begin
        phase    <= PH_BITS;
        sda_oe_o <= 1'b0;
        bit_cnt  <= 4'd0;
        hdr_idx  <= 2'd0;
        data_idx <= '0;
        cnt_q    <= 8'd0;
        cmd_ok   <= 1'b0;
      end else begin
        case (phase)
          PH_BITS: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (hdr_idx == 2'd0 && !(shreg[7:1] == DEV_ADDR && !shreg[0])) begin
                phase <= PH_SKIP;
              end else begin
                phase    <= PH_ACK;
                sda_oe_o <= 1'b1;
              end
              if (hdr_idx == 2'd1) cmd_ok <= (shreg == CMD_CODE);
              if (hdr_idx == 2'd2) cnt_q <= shreg;
              if (hdr_idx == 2'd3 && store_ok) begin
                we_o    <= 1'b1;
                waddr_o <= AW'(data_idx);
                wdata_o <= shreg;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              phase    <= PH_BITS;
              bit_cnt  <= 4'd0;
              if (hdr_idx != 2'd3) hdr_idx <= hdr_idx + 2'd1;
              else if (data_idx != CW'(MAX_CNT + 1)) data_idx <= data_idx + CW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: a start condition opens a fresh address byte
  a_r1_start_opens_addr: assert property (@(posedge clk) disable iff (rst || pdn_i)
    start_evt |=> (phase == PH_BITS && bit_cnt == 4'd0 && hdr_idx == 2'd0));

  // R3: the acknowledge is held through the SCL high phase of the ninth clock
  a_r3_ack_held_on_rise: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_o && scl_rise && !start_evt && !stop_evt && !pdn_i) |=> sda_oe_o);

  // R6: a stop returns the target to idle and releases SDA
  a_r6_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (phase == PH_IDLE && !sda_oe_o));

  // R7: power-down keeps the bus and the bank untouched
  a_r7_pdn_quiet: assert property (@(posedge clk) disable iff (rst)
    pdn_i |=> (!sda_oe_o && !we_o));
endmodule

// File: rtl/cfgw_bank.sv
module cfgw_bank #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NREG*DW-1:0] cfg_o
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_o[g*DW +: DW] = mem[g];
  end

  // R5: the control side never writes outside the bank
  a_r5_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    we_i |-> (int'(waddr_i) < NREG));

  // R7: without a write strobe the bank holds every value
  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(cfg_o));
endmodule

// File: rtl/cfg_blkwr_slave.sv
module cfg_blkwr_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] CMD_CODE    = 8'h00,
  parameter int         NREG        = 32,
  parameter int         MAX_CNT     = 32,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] cfg_o
);
  logic          sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic          we;
  logic [AW-1:0] waddr;
  logic [7:0]    wdata;

  cfgw_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  cfgw_xfer #(
    .DEV_ADDR(DEV_ADDR), .CMD_CODE(CMD_CODE), .NREG(NREG), .MAX_CNT(MAX_CNT)
  ) xfer_i (
    .clk(clk), .rst(rst), .pdn_i(pdn_i), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_oe_o(sda_oe_o), .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
  );

  cfgw_bank #(.NREG(NREG), .DW(8)) bank_i (
    .clk(clk), .rst(rst), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .cfg_o(cfg_o)
  );
endmodule

// File: tb/cfg_blkwr_slave_tb.sv
`timescale 1ns/1ps
module cfg_blkwr_slave_tb_top;
  localparam int         NREG = 32;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int         H    = 16;
  localparam int         NV   = 10;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] cmd;
    logic [7:0] cnt;
    logic [7:0] nsend;
    logic [7:0] seed;
  } vec_t;

  // address byte, command, length, bytes actually sent, data seed
  localparam vec_t VECS [NV] = '{
    '{8'hD2, 8'h00, 8'd4,  8'd4,  8'h10},   // plain write
    '{8'hD2, 8'h00, 8'd1,  8'd1,  8'hA0},   // minimum length
    '{8'hD2, 8'h00, 8'd32, 8'd34, 8'h33},   // maximum length, extra bytes
    '{8'hD2, 8'h00, 8'd3,  8'd6,  8'h55},   // more bytes than length
    '{8'hD2, 8'h00, 8'd0,  8'd2,  8'h77},   // length 0 illegal
    '{8'hD2, 8'h00, 8'd40, 8'd3,  8'h88},   // length above 32 illegal
    '{8'hD2, 8'h05, 8'd2,  8'd2,  8'h99},   // wrong command
    '{8'h00, 8'h00, 8'd2,  8'd2,  8'h44},   // general call
    '{8'hD3, 8'h00, 8'd2,  8'd2,  8'h66},   // read request
    '{8'hD4, 8'h00, 8'd2,  8'd2,  8'h22}    // other device
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdn = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [NREG*8-1:0] cfg;
  logic [7:0] model [NREG];
  int checks = 0;
  int errors = 0;
  int r8_bad = 0;
  logic ack_win = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  cfg_blkwr_slave dut_i (
    .clk(clk), .rst(rst), .pdn_i(pdn), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  always @(negedge clk) if (!rst && sda_oe && !ack_win) r8_bad++;

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] f;
    for (int k = 0; k < NREG; k++) f[k*8 +: 8] = model[k];
    return f;
  endfunction

  function automatic logic [7:0] dbyte(input logic [7:0] seed, input int k);
    return seed + 8'(k * 37);
  endfunction

  task automatic check(input string what, input logic [NREG*8-1:0] act,
                       input logic [NREG*8-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half();
    scl_m = 1'b1; half();
    sda_m = 1'b0; half();
    scl_m = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half();
    scl_m = 1'b1; half();
    sda_m = 1'b1; half();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; half();
      scl_m = 1'b1; half();
      scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    ack_win = 1'b1;
    sda_m = 1'b1; half();
    scl_m = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = sda_oe;
    repeat (H/2) @(negedge clk);
    scl_m = 1'b0;
    repeat (4) @(negedge clk);
    ack_win = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic a;
    logic exp_a;
    exp_a = (v.addr == {ADDR, 1'b0}) && !pdn;
    bus_start();
    send_byte(v.addr, a);
    check("R1 R2 address acknowledge", a, exp_a);
    send_byte(v.cmd, a);
    check("R3 command acknowledge", a, exp_a);
    send_byte(v.cnt, a);
    check("R3 length acknowledge", a, exp_a);
    for (int k = 0; k < int'(v.nsend); k++) begin
      send_byte(dbyte(v.seed, k), a);
      check("R3 R5 payload acknowledge", a, exp_a);
    end
    bus_stop();
    if (exp_a && v.cmd == 8'h00 && v.cnt >= 8'd1 && v.cnt <= 8'd32)
      for (int k = 0; k < int'(v.nsend) && k < int'(v.cnt) && k < NREG; k++)
        model[k] = dbyte(v.seed, k);
    repeat (8) @(negedge clk);
    check("R4 R5 register bank after transfer", cfg, model_flat());
  endtask

  initial begin
    logic a;
    for (int k = 0; k < NREG; k++) model[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 bank after reset", cfg, '0);
    check("R9 enable after reset", sda_oe, 1'b0);

    for (int v = 0; v < NV; v++) run_vec(VECS[v]);

    // R6: repeated start mid-payload, new header, load again from 0
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'd5, a);
    send_byte(8'hE1, a); send_byte(8'hE2, a);
    bus_start();
    send_byte(8'hD2, a);
    check("R6 address acknowledge after repeated start", a, 1'b1);
    send_byte(8'h00, a); send_byte(8'd1, a); send_byte(8'hF0, a);
    send_byte(8'hF1, a);
    bus_stop();
    model[0] = 8'hF0; model[1] = 8'hE2;
    repeat (8) @(negedge clk);
    check("R6 repeated start keeps earlier writes", cfg, model_flat());

    // R6: a transfer after a stop needs its own header (0x5A taken as command)
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h5A, a); send_byte(8'h01, a);
    send_byte(8'h3C, a);
    bus_stop();
    repeat (8) @(negedge clk);
    check("R6 new transfer needs its own header", cfg, model_flat());

    // R6: stop in the middle of a byte
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'd2, a);
    send_bits(8'hFF, 3);
    bus_stop();
    repeat (8) @(negedge clk);
    check("R6 stop mid-byte leaves bank", cfg, model_flat());

    // R7: power-down ignores a complete valid transfer
    pdn = 1'b1;
    run_vec('{8'hD2, 8'h00, 8'd3, 8'd3, 8'hC7});
    check("R7 no drive in power-down", sda_oe, 1'b0);
    pdn = 1'b0;
    repeat (8) @(negedge clk);
    run_vec('{8'hD2, 8'h00, 8'd2, 8'd2, 8'h5E});

    check("R8 enable only inside acknowledge windows", 32'(r8_bad), '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule